// File: doc/BRIEF.md
# Interrupt Redirection Router

This block collects a set of external interrupt lines and turns activity on each one into a message on an output channel with a valid/ready handshake. Each message carries an 8-bit vector, an 8-bit destination identifier and a destination-mode flag. Software sets up every line through a table entry. The entry holds a mask, a choice between edge and level triggering, the input polarity, the vector, the destination and the destination mode.

The host reaches all internal state through an indirect window of two words. It first writes an internal index into the select word, then reads or writes the data word, which maps onto the register that the index names. The internal registers are an identifier register, a read-only version register and the table. Each table entry takes two consecutive indices: a low word for control and a high word for the destination.

When several lines want service in the same cycle, the lowest-numbered line wins. Level-triggered lines are throttled by an in-service flag. A message sets this flag, and an acknowledge that carries the matching vector clears it.

Top module: `intr_router`

## Requirements
- R1: The select word is at byte offset 0x00 and reads back the selected index in bits 7:0. The data word is at offset 0x10. Read data appears on `rdata` in the cycle after `rd_en`. Any other offset reads zero, and writes to it are ignored.
- R2: Internal index 0x00 holds an 8-bit identifier in bits 31:24 that can be read and written. All its other bits read zero, and its reset value is zero.
- R3: Internal index 0x01 is read-only. It reads with bits 23:16 equal to the line count minus one (23 by default) and all other bits zero.
- R4: Entry n uses index 0x10+2n for the low word and 0x10+2n+1 for the high word. Low word fields: bit 16 mask, bit 15 level mode, bit 14 in-service (read-only), bit 13 active-low, bit 11 logical destination, bits 7:0 vector. High word field: bits 31:24 destination. After reset, each low word reads 0x00010000 and each high word reads 0.
- R5: An index that is neither 0x00, 0x01 nor inside the table reads zero, and writes to it change nothing.
- R6: A line whose mask bit is set never produces a message. An edge that arrives while the line is masked is discarded.
- R7: In edge mode, each change of a line from inactive to active produces exactly one message. Holding the line active does not repeat the message.
- R8: With the active-low bit set, a low input level counts as active. With it clear, a high level counts as active.
- R9: In level mode, sending a message sets the entry's in-service bit, and no further message goes out for that line while the bit is set. An acknowledge with a matching vector clears the bit, and the line sends again if it is still active. An acknowledge with any other vector has no effect.
- R10: A message carries the entry's vector, its destination (bits 31:24 of the high word) and its logical destination bit (bit 11 of the low word).
- R11: While `msg_valid` is high and `msg_ready` is low, the message stays valid and its fields stay unchanged.
- R12: When several lines are requesting at once, the lowest-numbered line is sent first, one message per accepted handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_in | input | N_LINES | Interrupt input lines |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by receiver |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination identifier |
| msg_logical | output | 1 | Message uses logical destination mode |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vector | input | 8 | Vector being acknowledged |

## Verification
The assertions assume that software changes the trigger mode or polarity of a line only while that line is masked. This matters because flipping the polarity of an unmasked line looks like a real edge. The stimulus therefore writes every new configuration with the mask bit set first, waits a few cycles, and only then clears the mask. The assertions also assume that acknowledges arrive only for vectors that are actually in use. The stimulus sends them only after the matching message has been observed, and it sends one deliberately mismatched vector, which must leave the line untouched.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;

  typedef struct packed {
    logic       mask;
    logic       level;
    logic       act_low;
    logic       logical;
    logic [7:0] vector;
    logic [7:0] dest;
  } rte_t;

  localparam rte_t RTE_RESET = '{mask: 1'b1, level: 1'b0, act_low: 1'b0,
                                 logical: 1'b0, vector: 8'h00, dest: 8'h00};

  localparam logic [4:0] OFS_SEL  = 5'h00;
  localparam logic [4:0] OFS_DATA = 5'h10;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_TBL  = 8'h10;

endpackage

// File: rtl/intr_router_regs.sv
module intr_router_regs
  import intr_router_pkg::*;
#(
  parameter int N_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [4:0]           addr,
  input  logic [31:0]          wdata,
  input  logic [N_LINES-1:0]   busy,
  output logic [31:0]          rdata,
  output rte_t [N_LINES-1:0]   tbl_o
);
  localparam int EW   = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam int LAST = int'(IDX_TBL) + 2 * N_LINES - 1;
  localparam logic [7:0] MAXENT = 8'(N_LINES - 1);

  logic [7:0]    sel_q;
  logic [7:0]    id_q;
  rte_t [N_LINES-1:0] tbl_q;
  logic          in_tbl;
  logic [7:0]    off;
  logic [EW-1:0] ent;
  logic          hi;
  logic [31:0]   rd_word;

  always_comb begin
    in_tbl = (int'(sel_q) >= int'(IDX_TBL)) && (int'(sel_q) <= LAST);
    off    = sel_q - IDX_TBL;
    ent    = off[EW:1];
    hi     = sel_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
      for (int i = 0; i < N_LINES; i++) tbl_q[i] <= RTE_RESET;
    end else if (wr_en) begin
      if (addr == OFS_SEL) begin
        sel_q <= wdata[7:0];
      end else if (addr == OFS_DATA) begin
        if (sel_q == IDX_ID) begin
          id_q <= wdata[31:24];
        end else if (in_tbl) begin
          if (hi) begin
            tbl_q[ent].dest <= wdata[31:24];
          end else begin
            tbl_q[ent].mask    <= wdata[16];
            tbl_q[ent].level   <= wdata[15];
            tbl_q[ent].act_low <= wdata[13];
            tbl_q[ent].logical <= wdata[11];
            tbl_q[ent].vector  <= wdata[7:0];
          end
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr == OFS_SEL) begin
      rd_word = {24'h0, sel_q};
    end else if (addr == OFS_DATA) begin
      if (sel_q == IDX_ID)       rd_word = {id_q, 24'h0};
      else if (sel_q == IDX_VER) rd_word = {8'h0, MAXENT, 16'h0};
      else if (in_tbl) begin
        if (hi) rd_word = {tbl_q[ent].dest, 24'h0};
        else    rd_word = {15'h0, tbl_q[ent].mask, tbl_q[ent].level, busy[ent],
                           tbl_q[ent].act_low, 1'b0, tbl_q[ent].logical, 3'b000,
                           tbl_q[ent].vector};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  assign tbl_o = tbl_q;

endmodule

// File: rtl/intr_router_line.sv
module intr_router_line
  import intr_router_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq,
  input  rte_t       cfg,
  input  logic       take,
  input  logic       ack_valid,
  input  logic [7:0] ack_vector,
  output logic       req,
  output logic       busy
);
  logic active, prev_q, pend_q, busy_q, rise;

  assign active = irq ^ cfg.act_low;
  assign rise   = active & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      prev_q <= active;
      pend_q <= ~cfg.mask & ~cfg.level & ((pend_q & ~take) | rise);
      if (take && cfg.level)
        busy_q <= 1'b1;
      else if (ack_valid && ack_vector == cfg.vector)
        busy_q <= 1'b0;
    end
  end

  assign req  = ~cfg.mask & (cfg.level ? (active & ~busy_q) : pend_q);
  assign busy = busy_q;

endmodule

// File: rtl/intr_router_arb.sv
module intr_router_arb #(
  parameter int N_LINES = 24
) (
  input  logic [N_LINES-1:0] req,
  output logic [N_LINES-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intr_router.sv
module intr_router
  import intr_router_pkg::*;
#(
  parameter int N_LINES = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [4:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [7:0]         msg_vector,
  output logic [7:0]         msg_dest,
  output logic               msg_logical,
  input  logic               ack_valid,
  input  logic [7:0]         ack_vector
);
  rte_t [N_LINES-1:0] tbl;
  logic [N_LINES-1:0] req_w, busy_w, grant_w, mask_w, level_w;
  logic               take_any;
  rte_t               pick;

  intr_router_regs #(.N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy(busy_w), .rdata(rdata), .tbl_o(tbl)
  );

  assign take_any = ~msg_valid & (|req_w);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    intr_router_line u_line (
      .clk(clk), .rst(rst), .irq(irq_in[g]), .cfg(tbl[g]),
      .take(take_any & grant_w[g]), .ack_valid(ack_valid),
      .ack_vector(ack_vector), .req(req_w[g]), .busy(busy_w[g])
    );
    assign mask_w[g]  = tbl[g].mask;
    assign level_w[g] = tbl[g].level;
  end

  intr_router_arb #(.N_LINES(N_LINES)) u_arb (.req(req_w), .grant(grant_w));

  always_comb begin
    pick = '0;
    for (int i = 0; i < N_LINES; i++)
      if (grant_w[i]) pick = pick | tbl[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid   <= 1'b0;
      msg_vector  <= '0;
      msg_dest    <= '0;
      msg_logical <= 1'b0;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end else if (take_any) begin
      msg_valid   <= 1'b1;
      msg_vector  <= pick.vector;
      msg_dest    <= pick.dest;
      msg_logical <= pick.logical;
    end
  end

endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk #(
  parameter int N_LINES = 24
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] req,
  input logic [N_LINES-1:0] grant,
  input logic [N_LINES-1:0] mask_bits,
  input logic [N_LINES-1:0] level_bits,
  input logic [N_LINES-1:0] busy,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [7:0]         msg_vector,
  input logic [7:0]         msg_dest
);
  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req & mask_bits) == '0);

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req & busy & level_bits) == '0);

  // R12
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R12
  grant_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> (((grant & req) == grant) && (((grant - 1'b1) & req) == '0)));

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)));
endmodule

bind intr_router intr_router_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .req(req_w), .grant(grant_w), .mask_bits(mask_w),
  .level_bits(level_w), .busy(busy_w), .msg_valid(msg_valid),
  .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest)
);

// File: tb/sim_intr_router.sv
`timescale 1ns/1ps
module sim_intr_router;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, msg_ready = 1, ack_valid = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] irq_in = '0;
  logic msg_valid, msg_logical;
  logic [7:0] msg_vector, msg_dest, ack_vector = '0;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [16:0] exp_q[$];

  always #2.5 clk = ~clk;

  intr_router #(.N_LINES(N)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
    .msg_logical(msg_logical), .ack_valid(ack_valid), .ack_vector(ack_vector)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [31:0] d);
    tick(); wr_en = 1; addr = 5'h00; wdata = {24'h0, idx};
    tick(); addr = 5'h10; wdata = d;
    tick(); wr_en = 0;
  endtask

  task automatic raw_rd(logic [4:0] a, output logic [31:0] d);
    tick(); rd_en = 1; addr = a;
    tick(); rd_en = 0; d = rdata;
  endtask

  task automatic reg_rd(logic [7:0] idx, output logic [31:0] d);
    tick(); wr_en = 1; addr = 5'h00; wdata = {24'h0, idx};
    tick(); wr_en = 0;
    raw_rd(5'h10, d);
  endtask

  task automatic expect_msg(bit logical, logic [7:0] dest, logic [7:0] vec);
    exp_q.push_back({logical, dest, vec});
  endtask

  task automatic send_ack(logic [7:0] v);
    tick(); ack_valid = 1; ack_vector = v;
    tick(); ack_valid = 0;
  endtask

  task automatic drain(string tag);
    tick(20);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R6/R7 unexpected message", {15'h0, msg_logical, msg_dest, msg_vector}, 0);
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        check({msg_logical, msg_dest, msg_vector} == e, "R10/R12 message fields",
              {15'h0, msg_logical, msg_dest, msg_vector}, {15'h0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3); rst = 0; tick(2);

    check(msg_valid == 0, "R11 reset valid", msg_valid, 0);
    reg_rd(8'h00, d); check(d == 0, "R2 reset id", d, 0);

    // R1 select readback and undefined offset
    tick(); wr_en = 1; addr = 5'h00; wdata = 32'hFFFF_FF2A; tick(); wr_en = 0;
    raw_rd(5'h00, d); check(d == 32'h2A, "R1 select readback", d, 32'h2A);
    tick(); wr_en = 1; addr = 5'h08; wdata = 32'hFFFF_FFFF; tick(); wr_en = 0;
    raw_rd(5'h08, d); check(d == 0, "R1 other offset", d, 0);
    raw_rd(5'h00, d); check(d == 32'h2A, "R1 other offset write ignored", d, 32'h2A);

    // R2 id
    reg_wr(8'h00, 32'hFFFF_FFFF); reg_rd(8'h00, d);
    check(d == 32'hFF00_0000, "R2 id bits", d, 32'hFF00_0000);

    // R3 version
    reg_rd(8'h01, d); check(d == 32'h0017_0000, "R3 version", d, 32'h0017_0000);
    reg_wr(8'h01, 32'h1234_5678); reg_rd(8'h01, d);
    check(d == 32'h0017_0000, "R3 version read-only", d, 32'h0017_0000);

    // R4 layout and reset
    reg_rd(8'h10, d); check(d == 32'h0001_0000, "R4 reset low 0", d, 32'h0001_0000);
    reg_rd(8'h11, d); check(d == 0, "R4 reset high 0", d, 0);
    reg_rd(8'h3E, d); check(d == 32'h0001_0000, "R4 reset low 23", d, 32'h0001_0000);
    reg_wr(8'h16, 32'h0001_4033); reg_rd(8'h16, d);
    check(d == 32'h0001_0033, "R4 busy not writable", d, 32'h0001_0033);
    reg_wr(8'h17, 32'h05FF_FFFF); reg_rd(8'h17, d);
    check(d == 32'h0500_0000, "R4 high word", d, 32'h0500_0000);

    // R5 undefined indices
    reg_wr(8'h40, 32'hFFFF_FFFF); reg_rd(8'h40, d); check(d == 0, "R5 idx 0x40", d, 0);
    reg_rd(8'h05, d); check(d == 0, "R5 idx 0x05", d, 0);

    // R7 edge on line 3
    reg_wr(8'h16, 32'h0000_0033); tick(3);
    expect_msg(0, 8'h05, 8'h33);
    irq_in[3] = 1; tick(10); irq_in[3] = 0;
    drain("R7 one message per edge");
    expect_msg(0, 8'h05, 8'h33);
    irq_in[3] = 1; tick(2); irq_in[3] = 0;
    drain("R7 second edge");

    // R6 masked line 4
    reg_wr(8'h18, 32'h0001_0044);
    irq_in[4] = 1; tick(3); irq_in[4] = 0;
    drain("R6 masked edge");
    reg_wr(8'h18, 32'h0000_0044);
    drain("R6 discarded edge after unmask");

    // R8 active-low line 5
    reg_wr(8'h1B, 32'h0600_0000);
    reg_wr(8'h1A, 32'h0001_2055); tick(3);
    reg_wr(8'h1A, 32'h0000_2055);
    drain("R8 idle-low no message");
    irq_in[5] = 1; tick(3);
    expect_msg(0, 8'h06, 8'h55);
    irq_in[5] = 0;
    drain("R8 falling edge message");

    // R9 level line 6
    reg_wr(8'h1D, 32'h0700_0000);
    reg_wr(8'h1C, 32'h0001_8066); tick(3);
    reg_wr(8'h1C, 32'h0000_8066);
    expect_msg(0, 8'h07, 8'h66);
    irq_in[6] = 1;
    drain("R9 single level message");
    reg_rd(8'h1C, d); check(d == 32'h0000_C066, "R9 busy set", d, 32'h0000_C066);
    send_ack(8'h65);
    drain("R9 wrong ack no resend");
    reg_rd(8'h1C, d); check(d == 32'h0000_C066, "R9 busy kept", d, 32'h0000_C066);
    expect_msg(0, 8'h07, 8'h66);
    send_ack(8'h66);
    drain("R9 resend after ack");
    irq_in[6] = 0; tick(2);
    send_ack(8'h66);
    drain("R9 quiet after release");
    reg_rd(8'h1C, d); check(d == 32'h0000_8066, "R9 busy cleared", d, 32'h0000_8066);

    // R12 / R11 / R10 priority and backpressure
    reg_wr(8'h1F, 32'h0800_0000); reg_wr(8'h1E, 32'h0000_0077);
    reg_wr(8'h23, 32'h0A00_0000); reg_wr(8'h22, 32'h0000_0899);
    tick(3);
    msg_ready = 0;
    expect_msg(0, 8'h08, 8'h77);
    expect_msg(1, 8'h0A, 8'h99);
    irq_in[9] = 1; irq_in[7] = 1; tick(2); irq_in[9] = 0; irq_in[7] = 0;
    tick(10);
    check(msg_valid == 1 && msg_vector == 8'h77, "R11/R12 held lowest line",
          {23'h0, msg_valid, msg_vector}, {23'h0, 1'b1, 8'h77});
    msg_ready = 1;
    drain("R12 both messages in order");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule